// File: doc/BRIEF.md
# Keyed Boot-Entry Gate

This block decides where a "jump to boot" subroutine instruction lands. Firmware running from flash first stores a byte into a memory-mapped key register. If the low six bits of that byte equal a fixed secret pattern, the block arms a key flag. The flag stays armed for a fixed number of instruction cycles and then drops by itself. A matching write that arrives while the flag is armed restarts the full window. A write that does not match changes nothing.

When the CPU decodes the jump-to-boot instruction, the block registers a target decision. If the key is armed, the target is the boot ROM entry address, and the key is consumed in the same cycle. If the key is not armed, the jump stays in flash at the address the instruction carries. A runaway program therefore cannot enter the boot ROM by accident.

The window counter advances only on instruction-cycle ticks. It holds its value while a debug breakpoint is active. Nothing else stops it: interrupt entry keeps consuming ticks, so the window can close before a service routine returns.

Top module: `boot_entry_gate`

## Requirements
- R1: After reset, keyLive is 0, tgtValid is 0, tgtBoot is 0 and tgtAddr is 0.
- R2: A cycle with keyWrEn high and keyWrData[5:0] equal to KEY_PAT (default 6'b100110) sets keyLive from the next cycle. Bits 7:6 of keyWrData do not affect the match.
- R3: A key write whose bits 5:0 differ from KEY_PAT has no effect. A clear keyLive stays clear, and an armed window keeps its remaining count.
- R4: Once armed, keyLive stays high for exactly WINDOW (default 8) cycles with cycTick high and brkActive low. It falls right after the WINDOW-th such cycle. Cycles with cycTick low do not count.
- R5: While brkActive is high, the window count holds its value even when cycTick is high. Counting resumes when brkActive falls.
- R6: A matching key write while keyLive is high reloads the full WINDOW count. This also holds when the write coincides with a tick.
- R7: jmpDecode while keyLive is high gives tgtValid=1, tgtBoot=1 and tgtAddr=BOOT_BASE in the next cycle, and keyLive is 0 from that same cycle.
- R8: jmpDecode while keyLive is low gives tgtValid=1, tgtBoot=0 and tgtAddr equal to the jmpFlashAddr sampled with the decode in the next cycle. tgtValid is high only in the cycle after a decode.
- R9: When a taken boot jump and a matching key write share a cycle, the jump consumes the key and the write is dropped, so keyLive is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyWrEn | input | 1 | Key register write strobe |
| keyWrData | input | DATA_W (8) | Byte written to the key register |
| cycTick | input | 1 | One pulse per instruction cycle |
| brkActive | input | 1 | Debug breakpoint condition active |
| jmpDecode | input | 1 | Jump-to-boot instruction decoded this cycle |
| jmpFlashAddr | input | ADDR_W (15) | Flash target carried by the instruction |
| keyLive | output | 1 | Key flag (window running) |
| tgtValid | output | 1 | Target decision valid (one-cycle pulse) |
| tgtBoot | output | 1 | 1 = boot ROM target, 0 = flash target |
| tgtAddr | output | ADDR_W (15) | Resolved jump target address |

## Verification
The assertions check on every cycle that only one counter action applies at a time, that a full reload follows each accepted write, and that a tick decrements the count by exactly one. They also check that a breakpoint freezes the count, that a non-matching write leaves a clear key clear, and that every decode yields a correctly steered and addressed target. Some behaviours need a whole sequence and only the bench scenarios can show them: the exact window length across interleaved stalls and idle cycles, a reload that extends the window past its first expiry, and a clean match decision for all 256 written byte values.

// File: rtl/boot_entry_gate_pkg.sv
package boot_entry_gate_pkg;

  // Strobes from the control module to the datapath. At most one of
  // winLoad, winDec, winClear is active in any cycle.
  typedef struct packed {
    logic winLoad;   // restart the window at its full count
    logic winDec;    // consume one instruction cycle of the window
    logic winClear;  // key consumed by a taken boot jump
    logic tgtCap;    // capture a jump target decision
    logic tgtToBoot; // the captured decision points into boot ROM
  } gateStb_t;

endpackage

// File: rtl/boot_entry_gate_ctrl.sv
module boot_entry_gate_ctrl
  import boot_entry_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     keyWrEn,
  input  logic     keyHit,
  input  logic     winArmed,
  input  logic     cycTick,
  input  logic     brkActive,
  input  logic     jmpDecode,
  output gateStb_t stb
);

  logic jumpTaken;
  logic writeAccepted;

  always_comb begin
    jumpTaken     = jmpDecode && winArmed;
    // A taken jump consumes the key; a matching write in the same cycle is dropped.
    writeAccepted = keyWrEn && keyHit && !jumpTaken;

    stb           = '0;
    stb.winClear  = jumpTaken;
    stb.winLoad   = writeAccepted;
    stb.winDec    = winArmed && cycTick && !brkActive && !writeAccepted && !jumpTaken;
    stb.tgtCap    = jmpDecode;
    stb.tgtToBoot = winArmed;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.winLoad, stb.winDec, stb.winClear})); // R6

  AST_NO_COUNT_IN_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    brkActive |-> !stb.winDec); // R5

endmodule

// File: rtl/boot_entry_gate_dp.sv
module boot_entry_gate_dp
  import boot_entry_gate_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              KEY_W     = 6,
  parameter logic [KEY_W-1:0] KEY_PAT  = 6'b100110,
  parameter int              WINDOW    = 8,
  parameter int              ADDR_W    = 15,
  parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
  localparam int             CNT_W     = $clog2(WINDOW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] flashAddr,
  output logic              keyHit,
  output logic              winArmed,
  output logic [CNT_W-1:0]  winLeft,
  output logic              tgtValid,
  output logic              tgtBoot,
  output logic [ADDR_W-1:0] tgtAddr
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cntQ;
  logic             unusedHighBits;

  // Only the low KEY_W bits take part in the match.
  assign keyHit         = (wrData[KEY_W-1:0] == KEY_PAT);
  assign unusedHighBits = ^wrData[DATA_W-1:KEY_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (stb.winClear) begin
      cntQ <= '0;
    end else if (stb.winLoad) begin
      cntQ <= CNT_FULL;
    end else if (stb.winDec) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtValid <= 1'b0;
      tgtBoot  <= 1'b0;
      tgtAddr  <= '0;
    end else begin
      tgtValid <= stb.tgtCap;
      if (stb.tgtCap) begin
        tgtBoot <= stb.tgtToBoot;
        tgtAddr <= stb.tgtToBoot ? BOOT_BASE : flashAddr;
      end
    end
  end

  assign winArmed = (cntQ != '0);
  assign winLeft  = cntQ;

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_FULL); // R4

endmodule

// File: rtl/boot_entry_gate.sv
module boot_entry_gate
  import boot_entry_gate_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               KEY_W     = 6,
  parameter logic [KEY_W-1:0]  KEY_PAT   = 6'b100110,
  parameter int               WINDOW    = 8,
  parameter int               ADDR_W    = 15,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 15'h7C00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWrEn,
  input  logic [DATA_W-1:0] keyWrData,
  input  logic              cycTick,
  input  logic              brkActive,
  input  logic              jmpDecode,
  input  logic [ADDR_W-1:0] jmpFlashAddr,
  output logic              keyLive,
  output logic              tgtValid,
  output logic              tgtBoot,
  output logic [ADDR_W-1:0] tgtAddr
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);

  gateStb_t         stb;
  logic             keyHit;
  logic             winArmed;
  logic [CNT_W-1:0] winLeft;

  boot_entry_gate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .keyWrEn   (keyWrEn),
    .keyHit    (keyHit),
    .winArmed  (winArmed),
    .cycTick   (cycTick),
    .brkActive (brkActive),
    .jmpDecode (jmpDecode),
    .stb       (stb)
  );

  boot_entry_gate_dp #(
    .DATA_W    (DATA_W),
    .KEY_W     (KEY_W),
    .KEY_PAT   (KEY_PAT),
    .WINDOW    (WINDOW),
    .ADDR_W    (ADDR_W),
    .BOOT_BASE (BOOT_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (keyWrData),
    .flashAddr (jmpFlashAddr),
    .keyHit    (keyHit),
    .winArmed  (winArmed),
    .winLeft   (winLeft),
    .tgtValid  (tgtValid),
    .tgtBoot   (tgtBoot),
    .tgtAddr   (tgtAddr)
  );

  assign keyLive = winArmed;

  // Port-level checks against the requirements.
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && keyWrData[KEY_W-1:0] == KEY_PAT && !(jmpDecode && keyLive))
      |=> (winLeft == CNT_FULL)); // R6

  AST_MISS_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!keyLive && !(keyWrEn && keyWrData[KEY_W-1:0] == KEY_PAT)) |=> !keyLive); // R3

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (keyLive && cycTick && !brkActive && !keyWrEn && !jmpDecode)
      |=> (winLeft == $past(winLeft) - 1'b1)); // R4

  AST_BREAK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (brkActive && !keyWrEn && !jmpDecode) |=> $stable(winLeft)); // R5

  AST_BOOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (jmpDecode && keyLive) |=> (tgtValid && tgtBoot && tgtAddr == BOOT_BASE && !keyLive)); // R7

  AST_FLASH_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (jmpDecode && !keyLive) |=> (tgtValid && !tgtBoot && tgtAddr == $past(jmpFlashAddr))); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !jmpDecode |=> !tgtValid); // R8

endmodule

// File: tb/boot_entry_gate_bench.sv
module boot_entry_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0]  PAT  = 6'b100110;
  localparam logic [14:0] BOOT = 15'h7C00;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        keyWrEn;
  logic [7:0]  keyWrData;
  logic        cycTick;
  logic        brkActive;
  logic        jmpDecode;
  logic [14:0] jmpFlashAddr;
  logic        keyLive;
  logic        tgtValid;
  logic        tgtBoot;
  logic [14:0] tgtAddr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_entry_gate u_boot_entry_gate (
    .clk          (clk),
    .rstN         (rstN),
    .keyWrEn      (keyWrEn),
    .keyWrData    (keyWrData),
    .cycTick      (cycTick),
    .brkActive    (brkActive),
    .jmpDecode    (jmpDecode),
    .jmpFlashAddr (jmpFlashAddr),
    .keyLive      (keyLive),
    .tgtValid     (tgtValid),
    .tgtBoot      (tgtBoot),
    .tgtAddr      (tgtAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge; results are visible just after the rising edge.
  task automatic cyc(input logic wr, input logic [7:0] d, input logic tk,
                     input logic bk, input logic jp, input logic [14:0] a);
    @(negedge clk);
    keyWrEn = wr; keyWrData = d; cycTick = tk; brkActive = bk;
    jmpDecode = jp; jmpFlashAddr = a;
    @(posedge clk);
    #1;
    keyWrEn = 1'b0; cycTick = 1'b0; brkActive = 1'b0; jmpDecode = 1'b0;
  endtask

  task automatic armKey(input logic [1:0] hi);
    cyc(1'b1, {hi, PAT}, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic flushKey();
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 15'h0123);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; keyWrEn = 1'b0; keyWrData = '0; cycTick = 1'b0;
    brkActive = 1'b0; jmpDecode = 1'b0; jmpFlashAddr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 keyLive", 32'(keyLive), 0);
    chk("R1 tgtValid", 32'(tgtValid), 0);
    chk("R1 tgtBoot", 32'(tgtBoot), 0);
    chk("R1 tgtAddr", 32'(tgtAddr), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2/R3/R7/R8: every written byte value, followed by a jump.
    for (int v = 0; v < 256; v++) begin
      logic match;
      logic [14:0] fa;
      match = (v[5:0] == PAT);
      fa = 15'((v * 37 + 5) & 16'h7FFF);
      cyc(1'b1, 8'(v), 1'b0, 1'b0, 1'b0, '0);
      chk(match ? "R2 arm on match" : "R3 miss leaves clear", 32'(keyLive), 32'(match));
      chk("R8 no valid without decode", 32'(tgtValid), 0);
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, fa);
      chk("R7/R8 valid", 32'(tgtValid), 1);
      chk(match ? "R7 boot select" : "R8 flash select", 32'(tgtBoot), 32'(match));
      chk(match ? "R7 boot addr" : "R8 flash addr", 32'(tgtAddr), match ? 32'(BOOT) : 32'(fa));
      chk("R7 key consumed", 32'(keyLive), 0);
    end

    // R4/R5: the window spans WIN counted ticks, with stalls and idle cycles interleaved.
    for (int k = 1; k <= WIN; k++) begin
      armKey(2'(k));
      for (int i = 0; i < k; i++) begin
        cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, '0);
        chk("R5 break holds window", 32'(keyLive), 1);
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
        chk("R4 idle cycle not counted", 32'(keyLive), 1);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
        chk("R4 window after counted tick", 32'(keyLive), 32'(i + 1 < WIN));
      end
      if (keyLive) flushKey();
    end

    // R5: a long breakpoint does not drain the window.
    armKey(2'b00);
    repeat (3) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    repeat (20) cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, '0);
    repeat (WIN - 4) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R5 resumes after break", 32'(keyLive), 1);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R5 expires at full count", 32'(keyLive), 0);

    // R3: a mismatched write while armed keeps the remaining count.
    armKey(2'b01);
    repeat (3) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    cyc(1'b1, {2'b00, ~PAT}, 1'b1, 1'b0, 1'b0, '0);
    repeat (WIN - 5) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R3 armed count kept", 32'(keyLive), 1);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R3 no extension on miss", 32'(keyLive), 0);

    // R6: reload while armed, also when the write meets a tick.
    armKey(2'b10);
    repeat (5) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    cyc(1'b1, {2'b11, PAT}, 1'b1, 1'b0, 1'b0, '0);
    repeat (WIN - 1) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R6 reload extends window", 32'(keyLive), 1);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    chk("R6 reloaded window ends", 32'(keyLive), 0);

    // R9: a taken jump and a matching write in one cycle.
    armKey(2'b00);
    cyc(1'b1, {2'b00, PAT}, 1'b0, 1'b0, 1'b1, 15'h0456);
    chk("R9 boot taken", 32'(tgtBoot), 1);
    chk("R9 write dropped", 32'(keyLive), 0);
    // R2: a write together with a non-taken jump still arms.
    cyc(1'b1, {2'b00, PAT}, 1'b0, 1'b0, 1'b1, 15'h0456);
    chk("R8 flash when clear", 32'(tgtBoot), 0);
    chk("R2 arms beside flash jump", 32'(keyLive), 1);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
    chk("R8 valid is one pulse", 32'(tgtValid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule